// File: doc/BRIEF.md
# NAND Sector Hamming Code Checker and Corrector

This block handles the single-error-correcting Hamming code that protects one NAND sector of up to 512 bytes. On the write path it takes the 32-bit raw parity word from the hardware parity accumulator. It removes the two unused nibbles and inverts what is left, which gives the 24-bit code that goes into the spare area. The code travels as three bytes, least significant byte first. Because the code is inverted, a fully erased page reads back as a code that matches its data.

On the read path a request carries two codes: the one read from the spare area and the one the accumulator just produced from the data. It also carries the sector length in bytes. The block XORs the two codes to form a syndrome and sorts the result into one of four outcomes:

- clean;
- a single flipped data bit, reported as a byte offset and a one-hot bit mask that the page-buffer logic applies with XOR;
- a single flipped bit inside the stored code, with no data change needed;
- uncorrectable.

The result is registered once and appears on the cycle after the request is accepted.

Top module: `nand_ecc_fixer`

## Requirements
- R1: `packed_code_o` is the bitwise inverse of {raw bits 27:16, raw bits 11:0}, in that order from MSB to LSB. It is combinational. Raw bits 31:28 and 15:12 have no effect on it. Bits 7:0 form the first byte stored.
- R2: A raw word whose bits 27:16 and 11:0 are all zero packs to 24'hFFFFFF, the value an erased spare area reads back as. Comparing it with an erased stored code (24'hFFFFFF) gives status 0.
- R3: When the stored and computed codes are equal (zero syndrome), status is 0 (clean), offset is 0 and mask is 0.
- R4: Let the syndrome be stored XOR computed. If syndrome bits 11:0 XOR bits 23:12 equal 12'hFFF and the offset in syndrome bits 23:15 is below `sector_bytes_i`, then:
  - status is 1 (data corrected);
  - offset is syndrome bits 23:15;
  - mask is 1 shifted left by syndrome bits 14:12.
- R5: A syndrome with the complementary-halves pattern whose offset is not below `sector_bytes_i` gives status 3 (uncorrectable), offset 0 and mask 0.
- R6: A syndrome with exactly one bit set gives status 2 (code-only error), offset 0 and mask 0.
- R7: Every other nonzero syndrome gives status 3, offset 0 and mask 0.
- R8: `req_ready_o` is always 1. `res_valid_o` is 1 exactly in the cycle after a cycle in which `req_valid_i` was 1. While no request arrives, the status, offset and mask outputs hold their last values.
- R9: After reset, `res_valid_o`, status, offset and mask are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_parity_i | input | 32 | Raw parity word from the accumulator |
| packed_code_o | output | 24 | Inverted packed code for storage |
| req_valid_i | input | 1 | Compare request valid |
| req_ready_o | output | 1 | Compare request ready (always 1) |
| stored_code_i | input | 24 | Code read back from the spare area |
| calc_code_i | input | 24 | Code computed from the data just read |
| sector_bytes_i | input | 10 | Sector length in bytes, normally 512 |
| res_valid_o | output | 1 | Result valid |
| res_status_o | output | 2 | 0 clean, 1 data corrected, 2 code error, 3 uncorrectable |
| res_offset_o | output | 9 | Byte offset of the flipped data bit |
| res_mask_o | output | 8 | One-hot mask of the flipped bit in that byte |

## Verification
The packed code is combinational, so the bench checks it a short delay after it drives the raw word, within the same cycle. Compare results pass through one register. The bench drives each request on a falling edge and reads status, offset and mask on the next falling edge, which is exactly one rising edge later; back-to-back requests are checked in that same rhythm. Idle cycles are checked on the falling edge that follows them, to confirm that valid drops and that the result fields hold.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int RAW_W  = 32;
  localparam int HALF_W = 12;
  localparam int CODE_W = 2 * HALF_W;
  localparam int BIT_W  = 3;
  localparam int MASK_W = 1 << BIT_W;
  localparam int OFF_W  = CODE_W - HALF_W - BIT_W;
  localparam int SIZE_W = OFF_W + 1;
  localparam int HI_LSB = 16;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_DATA  = 2'd1,
    ST_CODE  = 2'd2,
    ST_FAIL  = 2'd3
  } ecc_status_e;
endpackage

// File: rtl/ecc_code_pack.sv
module ecc_code_pack
  import ecc_pkg::*;
(
  input  logic [RAW_W-1:0]  raw_i,
  output logic [CODE_W-1:0] code_o
);
  // drop reserved nibbles above each 12-bit field, invert so erased reads match
  assign code_o = ~{raw_i[HI_LSB +: HALF_W], raw_i[HALF_W-1:0]};
endmodule

// File: rtl/ecc_syndrome_classify.sv
module ecc_syndrome_classify
  import ecc_pkg::*;
(
  input  logic [CODE_W-1:0] syn_i,
  input  logic [SIZE_W-1:0] sector_i,
  output ecc_status_e       status_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic [MASK_W-1:0] mask_o
);
  logic              compl_halves;
  logic              single_bit;
  logic [OFF_W-1:0]  off;
  logic [BIT_W-1:0]  bit_idx;

  assign compl_halves = &(syn_i[HALF_W-1:0] ^ syn_i[CODE_W-1:HALF_W]);
  assign single_bit   = ((syn_i & (syn_i - 1'b1)) == '0);
  assign off          = syn_i[CODE_W-1 -: OFF_W];
  assign bit_idx      = syn_i[HALF_W +: BIT_W];

  always_comb begin
    status_o = ST_CLEAN;
    offset_o = '0;
    mask_o   = '0;
    if (syn_i == '0) begin
      status_o = ST_CLEAN;
    end else if (compl_halves) begin
      if (SIZE_W'(off) < sector_i) begin
        status_o = ST_DATA;
        offset_o = off;
        mask_o   = MASK_W'(1) << bit_idx;
      end else begin
        status_o = ST_FAIL;
      end
    end else if (single_bit) begin
      status_o = ST_CODE;
    end else begin
      status_o = ST_FAIL;
    end
  end
endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
  import ecc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RAW_W-1:0]  raw_parity_i,
  output logic [CODE_W-1:0] packed_code_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CODE_W-1:0] stored_code_i,
  input  logic [CODE_W-1:0] calc_code_i,
  input  logic [SIZE_W-1:0] sector_bytes_i,
  output logic              res_valid_o,
  output logic [1:0]        res_status_o,
  output logic [OFF_W-1:0]  res_offset_o,
  output logic [MASK_W-1:0] res_mask_o
);
  ecc_status_e       cls_status;
  logic [OFF_W-1:0]  cls_offset;
  logic [MASK_W-1:0] cls_mask;
  logic [CODE_W-1:0] syndrome;

  assign req_ready_o = 1'b1;
  assign syndrome    = stored_code_i ^ calc_code_i;

  ecc_code_pack u_pack (
    .raw_i  (raw_parity_i),
    .code_o (packed_code_o)
  );

  ecc_syndrome_classify u_cls (
    .syn_i    (syndrome),
    .sector_i (sector_bytes_i),
    .status_o (cls_status),
    .offset_o (cls_offset),
    .mask_o   (cls_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_status_o <= ST_CLEAN;
      res_offset_o <= '0;
      res_mask_o   <= '0;
    end else begin
      res_valid_o <= req_valid_i;
      if (req_valid_i) begin
        res_status_o <= cls_status;
        res_offset_o <= cls_offset;
        res_mask_o   <= cls_mask;
      end
    end
  end

  a_r8_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!res_valid_o && $stable(res_status_o) && $stable(res_mask_o)));

  a_r3_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && stored_code_i == calc_code_i) |=>
      (res_status_o == ST_CLEAN && res_mask_o == '0));

  a_r4_mask_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_status_o == ST_DATA) |-> ($countones(res_mask_o) == 1));

  a_r5_in_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (res_status_o != ST_DATA ||
                     SIZE_W'(res_offset_o) < $past(sector_bytes_i)));

  a_r6_code_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && $countones(stored_code_i ^ calc_code_i) == 1) |=>
      (res_status_o == ST_CODE && res_mask_o == '0));
endmodule

// File: tb/tb_nand_ecc_fixer.sv
module tb_nand_ecc_fixer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] raw_parity_i = '0;
  logic [23:0] packed_code_o;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [23:0] stored_code_i = '0;
  logic [23:0] calc_code_i = '0;
  logic [9:0]  sector_bytes_i = 10'd512;
  logic        res_valid_o;
  logic [1:0]  res_status_o;
  logic [8:0]  res_offset_o;
  logic [7:0]  res_mask_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  nand_ecc_fixer dut (.*);

  function automatic logic [18:0] expect_res(input logic [23:0] s, input logic [23:0] c,
                                             input logic [9:0] size);
    logic [23:0] syn;
    logic [8:0]  off;
    syn = s ^ c;
    off = syn[23:15];
    if (syn == 24'd0) return {2'd0, 9'd0, 8'd0};
    if (syn[11:0] == ~syn[23:12]) begin
      if ({1'b0, off} < size) return {2'd1, off, 8'd1 << syn[14:12]};
      return {2'd3, 9'd0, 8'd0};
    end
    if ($countones(syn) == 1) return {2'd2, 9'd0, 8'd0};
    return {2'd3, 9'd0, 8'd0};
  endfunction

  function automatic logic [23:0] expect_pack(input logic [31:0] r);
    logic [23:0] v;
    for (int i = 0; i < 12; i++) begin
      v[i]      = ~r[i];
      v[i + 12] = ~r[i + 16];
    end
    return v;
  endfunction

  function automatic logic [23:0] make_corr(input logic [8:0] off, input logic [2:0] b);
    logic [11:0] hi;
    hi = {off, b};
    return {hi, ~hi};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on negedge, result due on the following negedge
  task automatic run_req(input string req, input logic [23:0] s, input logic [23:0] c,
                         input logic [9:0] size);
    logic [18:0] e;
    e = expect_res(s, c, size);
    stored_code_i  = s;
    calc_code_i    = c;
    sector_bytes_i = size;
    req_valid_i    = 1'b1;
    @(negedge clk_i);
    check(req, {12'd0, res_valid_o, res_status_o, res_offset_o, res_mask_o}, {12'd0, 1'b1, e});
  endtask

  initial begin
    logic [18:0] held;
    void'($urandom(32'd2024));
    @(negedge clk_i);
    check("R9 reset", {12'd0, res_valid_o, res_status_o, res_offset_o, res_mask_o}, 32'd0);
    check("R8 ready", {31'd0, req_ready_o}, 32'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // packing
    raw_parity_i = 32'h0000_0000; #1;
    check("R2 erased pack", {8'd0, packed_code_o}, 32'h00FF_FFFF);
    raw_parity_i = 32'hF000_F000; #1;
    check("R1 reserved ignored", {8'd0, packed_code_o}, 32'h00FF_FFFF);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] r;
      r = $urandom;
      raw_parity_i = r; #1;
      check("R1 pack", {8'd0, packed_code_o}, {8'd0, expect_pack(r)});
      raw_parity_i = r ^ 32'hF000_F000; #1;
      check("R1 reserved", {8'd0, packed_code_o}, {8'd0, expect_pack(r)});
    end
    @(negedge clk_i);

    // directed corners
    run_req("R2 erased compare", 24'hFFFFFF, expect_pack(32'd0), 10'd512);
    run_req("R3 clean", 24'h123456, 24'h123456, 10'd512);
    run_req("R4 last byte bit7", 24'h0, make_corr(9'd511, 3'd7), 10'd512);
    run_req("R4 first byte bit0", 24'hABCDEF, 24'hABCDEF ^ make_corr(9'd0, 3'd0), 10'd512);
    run_req("R5 offset equals size", 24'h0, make_corr(9'd256, 3'd2), 10'd256);
    run_req("R4 offset below size", 24'h0, make_corr(9'd256, 3'd2), 10'd257);
    run_req("R6 code bit23", 24'h800000, 24'h0, 10'd512);
    run_req("R6 code bit0", 24'h000001, 24'h0, 10'd512);
    run_req("R7 two bits", 24'h000003, 24'h0, 10'd512);
    run_req("R7 all ones", 24'hFFFFFF, 24'h0, 10'd512);

    // idle: valid drops, fields hold
    held = {res_status_o, res_offset_o, res_mask_o};
    req_valid_i = 1'b0;
    stored_code_i = 24'h0; calc_code_i = make_corr(9'd5, 3'd1);
    @(negedge clk_i);
    check("R8 idle", {12'd0, res_valid_o, res_status_o, res_offset_o, res_mask_o}, {12'd0, 1'b0, held});

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [23:0] c, syn;
      logic [9:0]  size;
      logic [8:0]  off;
      int kind;
      c    = 24'($urandom);
      kind = int'($urandom_range(0, 4));
      size = ($urandom_range(0, 3) == 0) ? 10'($urandom_range(1, 512)) : 10'd512;
      off  = 9'($urandom);
      case (kind)
        0: syn = 24'd0;
        1: begin
          if (size < 10'd512) off = 9'($urandom_range(0, int'(size) - 1));
          syn = make_corr(off, 3'($urandom));
        end
        2: begin
          if (size == 10'd512) size = 10'($urandom_range(1, 511));
          off = 9'($urandom_range(int'(size), 511));
          syn = make_corr(off, 3'($urandom));
        end
        3: syn = 24'd1 << $urandom_range(0, 23);
        default: syn = 24'($urandom);
      endcase
      case (kind)
        0: run_req("R3 random", c ^ syn, c, size);
        1: run_req("R4 random", c ^ syn, c, size);
        2: run_req("R5 random", c ^ syn, c, size);
        3: run_req("R6 random", c ^ syn, c, size);
        default: run_req("R7 random", c ^ syn, c, size);
      endcase
      if ($urandom_range(0, 7) == 0) begin
        held = {res_status_o, res_offset_o, res_mask_o};
        req_valid_i = 1'b0;
        @(negedge clk_i);
        check("R8 idle random", {12'd0, res_valid_o, res_status_o, res_offset_o, res_mask_o},
              {12'd0, 1'b0, held});
      end
    end
    req_valid_i = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule